// File: doc/BRIEF.md
# Sample-Adaptive Band Offset Stage

This block is the band offset correction step of a video decoder's in-loop filter. Pixels of 10-bit or 12-bit depth stream through it one per cycle under a valid/ready handshake. Each sample falls into one of 32 equal-width intensity bands. Four consecutive bands, starting at a programmable band, carry signed corrections. A sample in one of those bands gets its correction added. Every sample is then limited to the legal range for the chosen depth and sent out in arrival order.

Before each block, a configuration word is loaded. It holds the depth, the first active band, the four corrections, the block width and the row count. The block then takes exactly width × rows pixels. It flags the last pixel of every row and the last pixel of the block. After that it waits for the next configuration. A new configuration is taken only once the previous block has fully left the pipeline.

Top module: `sao_band_stage`

## Requirements
- R1: The band of a sample is its value shifted right by (depth − 5). Depth is 12 when `cfg_depth12` = 1 and 10 when it is 0, so there are always 32 bands.
- R2: The active bands are start, start+1, start+2 and start+3, each taken modulo 32. Band start+k uses the signed 16-bit correction in `cfg_band_offs[16k+15:16k]`, for k = 0..3.
- R3: A sample whose band is not active leaves the block with its value unchanged.
- R4: The sum of sample and correction is formed without wrap-around. It is then clipped to 0..2^depth−1 (0x3FF at 10 bits, 0xFFF at 12 bits).
- R5: In 10-bit mode, input bits 11:10 are ignored.
- R6: With `out_ready` held high, a pixel accepted in cycle N appears on `out_pixel` in cycle N+2. Outputs keep the input order, with no drop and no duplicate.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pixel`, `out_eol` and `out_eob` hold their values.
- R8: `cfg_ready` is high only when no block is open and the pipeline is empty, and `in_ready` is low then. The block accepts exactly W × (`cfg_rows_m1`+1) pixels. W is given by `cfg_width_sel`: 0→8, 1→16, 2→32, 3→48, and any other code → 64.
- R9: `out_eol` marks the last pixel of each row. `out_eob` marks the last pixel of the block, together with `out_eol`.
- R10: Configuration is captured on the cycle `cfg_valid` and `cfg_ready` are both high. Changes on the `cfg_*` inputs during a block have no effect on it.
- R11: After reset, `out_valid` and `in_ready` are low and `cfg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration offered |
| cfg_ready | output | 1 | Block idle and pipeline empty; configuration can be taken |
| cfg_depth12 | input | 1 | 1 = 12-bit samples, 0 = 10-bit samples |
| cfg_start_band | input | 5 | First of the four active bands |
| cfg_band_offs | input | 64 | Four signed 16-bit corrections, slot k in bits 16k+15:16k |
| cfg_width_sel | input | 3 | Block width code |
| cfg_rows_m1 | input | 16 | Rows in the block minus one |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | 12 | Input sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_pixel | output | 12 | Corrected, clipped sample |
| out_eol | output | 1 | Last pixel of a row |
| out_eob | output | 1 | Last pixel of the block |

## Verification
The checker watches several properties on every cycle:
- the output holds steady under backpressure;
- no more than two pixels are in flight, and no output appears without a matching input;
- no input is taken while the block waits for configuration;
- end-of-block always coincides with end-of-row;
- in a 10-bit block, no output exceeds ten bits.

Other properties need the bench's scenarios. These are the arithmetic of banding, the wrap of the active bands past band 31, the exact clipped values, the two-cycle latency, the pixel count and row flags for each width code, and the immunity to configuration changes during a block. The bench checks these against a model it computes on its own, sweeping every start band at both depths.

// File: rtl/sao_band_pkg.sv
package sao_band_pkg;

    localparam int SAO_DEPTH_LO = 10;
    localparam int SAO_DEPTH_HI = 12;
    localparam int SAO_BAND_W   = 5;
    localparam int SAO_MAX_W    = 64;
    localparam int SAO_COL_W    = $clog2(SAO_MAX_W);
    localparam int SAO_WSEL_W   = 3;

    typedef enum logic [SAO_WSEL_W-1:0] {
        WSEL_8  = 3'd0,
        WSEL_16 = 3'd1,
        WSEL_32 = 3'd2,
        WSEL_48 = 3'd3,
        WSEL_64 = 3'd4
    } wsel_e;

    // Index of the last column for a width code; unknown codes mean 64.
    function automatic logic [SAO_COL_W-1:0] sao_last_col(input logic [SAO_WSEL_W-1:0] sel);
        case (sel)
            WSEL_8:  sao_last_col = SAO_COL_W'(7);
            WSEL_16: sao_last_col = SAO_COL_W'(15);
            WSEL_32: sao_last_col = SAO_COL_W'(31);
            WSEL_48: sao_last_col = SAO_COL_W'(47);
            default: sao_last_col = SAO_COL_W'(SAO_MAX_W - 1);
        endcase
    endfunction

endpackage

// File: rtl/sao_band_classify.sv
module sao_band_classify #(
    parameter int PIX_W    = 12,
    parameter int DEPTH_LO = 10,
    parameter int BAND_W   = 5,
    parameter int OFF_W    = 16,
    parameter int N_ACT    = 4
) (
    input  logic [PIX_W-1:0]       pix,
    input  logic                   depth12,
    input  logic [BAND_W-1:0]      start,
    input  logic [N_ACT*OFF_W-1:0] offs,
    output logic [PIX_W-1:0]       samp,
    output logic [OFF_W-1:0]       off
);
    localparam int SH_LO = DEPTH_LO - BAND_W;
    localparam int SH_HI = PIX_W - BAND_W;

    logic [BAND_W-1:0] band;
    logic [BAND_W-1:0] rel;
    logic [N_ACT-1:0]  hit;
    logic [OFF_W-1:0]  masked [N_ACT];

    // Drop unused upper bits in the narrow depth.
    always_comb begin
        samp = depth12 ? pix : {{(PIX_W-DEPTH_LO){1'b0}}, pix[DEPTH_LO-1:0]};
        band = depth12 ? samp[SH_HI +: BAND_W] : samp[SH_LO +: BAND_W];
        rel  = band - start;
    end

    // Distance from the first active band, modulo the band count, picks the slot.
    for (genvar k = 0; k < N_ACT; k++) begin : g_slot
        assign hit[k]    = (rel == BAND_W'(k));
        assign masked[k] = hit[k] ? offs[k*OFF_W +: OFF_W] : '0;
    end

    always_comb begin
        off = '0;
        for (int k = 0; k < N_ACT; k++) begin
            off = off | masked[k];
        end
    end

endmodule

// File: rtl/sao_band_clip.sv
module sao_band_clip #(
    parameter int PIX_W    = 12,
    parameter int DEPTH_LO = 10,
    parameter int OFF_W    = 16
) (
    input  logic [PIX_W-1:0] samp,
    input  logic [OFF_W-1:0] off,
    input  logic             depth12,
    output logic [PIX_W-1:0] res
);
    localparam int SUM_W = OFF_W + 1;

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] maxv;

    always_comb begin
        sum  = $signed({{(SUM_W-PIX_W){1'b0}}, samp}) + $signed({off[OFF_W-1], off});
        maxv = depth12 ? SUM_W'((1 << PIX_W) - 1) : SUM_W'((1 << DEPTH_LO) - 1);
        if (sum < 0) begin
            res = '0;
        end else if (sum > maxv) begin
            res = maxv[PIX_W-1:0];
        end else begin
            res = sum[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/sao_band_flow.sv
module sao_band_flow (
    input  logic active,
    input  logic a_vld,
    input  logic b_vld,
    input  logic out_ready,
    output logic b_free,
    output logic a_free,
    output logic in_ready,
    output logic cfg_ready
);
    always_comb begin
        b_free    = !b_vld || out_ready;
        a_free    = !a_vld || b_free;
        in_ready  = active && a_free;
        cfg_ready = !active && !a_vld && !b_vld;
    end
endmodule

// File: rtl/sao_band_stage.sv
module sao_band_stage
    import sao_band_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int N_ACT  = 4,
    parameter int ROWS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_valid,
    output logic                    cfg_ready,
    input  logic                    cfg_depth12,
    input  logic [SAO_BAND_W-1:0]   cfg_start_band,
    input  logic [N_ACT*OFF_W-1:0]  cfg_band_offs,
    input  logic [SAO_WSEL_W-1:0]   cfg_width_sel,
    input  logic [ROWS_W-1:0]       cfg_rows_m1,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [SAO_DEPTH_HI-1:0] in_pixel,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [SAO_DEPTH_HI-1:0] out_pixel,
    output logic                    out_eol,
    output logic                    out_eob
);
    localparam int PIX_W = SAO_DEPTH_HI;
    localparam int TAB_W = N_ACT * OFF_W;

    typedef struct packed {
        logic                  active;
        logic                  depth12;
        logic [SAO_BAND_W-1:0] start;
        logic [TAB_W-1:0]      offs;
        logic [SAO_COL_W-1:0]  wlast;
        logic [ROWS_W-1:0]     rows_m1;
        logic [SAO_COL_W-1:0]  col;
        logic [ROWS_W-1:0]     row;
        logic                  a_vld;
        logic [PIX_W-1:0]      a_pix;
        logic [OFF_W-1:0]      a_off;
        logic                  a_d12;
        logic                  a_eol;
        logic                  a_eob;
        logic                  b_vld;
        logic [PIX_W-1:0]      b_pix;
        logic                  b_eol;
        logic                  b_eob;
    } st_t;

    st_t st_d, st_q;

    logic             b_free, a_free;
    logic             accept, cfg_take;
    logic             row_end, last_row;
    logic [PIX_W-1:0] cls_samp;
    logic [OFF_W-1:0] cls_off;
    logic [PIX_W-1:0] clip_res;

    sao_band_flow u_flow (
        .active    (st_q.active),
        .a_vld     (st_q.a_vld),
        .b_vld     (st_q.b_vld),
        .out_ready (out_ready),
        .b_free    (b_free),
        .a_free    (a_free),
        .in_ready  (in_ready),
        .cfg_ready (cfg_ready)
    );

    sao_band_classify #(
        .PIX_W    (PIX_W),
        .DEPTH_LO (SAO_DEPTH_LO),
        .BAND_W   (SAO_BAND_W),
        .OFF_W    (OFF_W),
        .N_ACT    (N_ACT)
    ) u_classify (
        .pix     (in_pixel),
        .depth12 (st_q.depth12),
        .start   (st_q.start),
        .offs    (st_q.offs),
        .samp    (cls_samp),
        .off     (cls_off)
    );

    sao_band_clip #(
        .PIX_W    (PIX_W),
        .DEPTH_LO (SAO_DEPTH_LO),
        .OFF_W    (OFF_W)
    ) u_clip (
        .samp    (st_q.a_pix),
        .off     (st_q.a_off),
        .depth12 (st_q.a_d12),
        .res     (clip_res)
    );

    always_comb begin
        accept   = in_valid && in_ready;
        cfg_take = cfg_valid && cfg_ready;
        row_end  = (st_q.col == st_q.wlast);
        last_row = (st_q.row == st_q.rows_m1);

        st_d = st_q;

        // Output stage: clip the held sum term.
        if (b_free) begin
            st_d.b_vld = st_q.a_vld;
            st_d.b_pix = clip_res;
            st_d.b_eol = st_q.a_eol;
            st_d.b_eob = st_q.a_eob;
        end

        // Entry stage: classify and pick the correction.
        if (a_free) begin
            st_d.a_vld = accept;
            st_d.a_pix = cls_samp;
            st_d.a_off = cls_off;
            st_d.a_d12 = st_q.depth12;
            st_d.a_eol = row_end;
            st_d.a_eob = row_end && last_row;
        end

        // Block framing.
        if (accept) begin
            if (row_end) begin
                st_d.col = '0;
                if (last_row) begin
                    st_d.row    = '0;
                    st_d.active = 1'b0;
                end else begin
                    st_d.row = st_q.row + ROWS_W'(1);
                end
            end else begin
                st_d.col = st_q.col + SAO_COL_W'(1);
            end
        end

        if (cfg_take) begin
            st_d.active  = 1'b1;
            st_d.depth12 = cfg_depth12;
            st_d.start   = cfg_start_band;
            st_d.offs    = cfg_band_offs;
            st_d.wlast   = sao_last_col(cfg_width_sel);
            st_d.rows_m1 = cfg_rows_m1;
            st_d.col     = '0;
            st_d.row     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.b_vld;
    assign out_pixel = st_q.b_pix;
    assign out_eol   = st_q.b_eol;
    assign out_eob   = st_q.b_eob;

endmodule

// File: rtl/sao_band_stage_chk.sv
module sao_band_stage_chk #(
    parameter int PIX_W    = 12,
    parameter int DEPTH_LO = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_valid,
    input logic             cfg_ready,
    input logic             cfg_depth12,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_pixel,
    input logic             out_eol,
    input logic             out_eob
);
    logic       blk_d12_q;
    logic [2:0] inflight_q;
    logic       acc, emit;

    assign acc  = in_valid && in_ready;
    assign emit = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_d12_q  <= 1'b0;
            inflight_q <= '0;
        end else begin
            if (cfg_valid && cfg_ready) blk_d12_q <= cfg_depth12;
            inflight_q <= inflight_q + 3'(acc) - 3'(emit);
        end
    end

    // R7: stalled output holds
    a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pixel) && $stable(out_eol) && $stable(out_eob));

    // R6: at most two pixels in flight
    a_r6_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> inflight_q <= 3'd2);

    // R6: no output without an accepted input
    a_r6_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight_q != 3'd0);

    // R8: idle block takes no pixels
    a_r8_idle_no_input: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> !in_ready && !out_valid);

    // R9: end of block is also end of row
    a_r9_eob_with_eol: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eob |-> out_eol);

    // R4: ten-bit blocks stay within ten bits
    a_r4_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !blk_d12_q |-> out_pixel[PIX_W-1:DEPTH_LO] == '0);

endmodule

bind sao_band_stage sao_band_stage_chk #(
    .PIX_W    (sao_band_pkg::SAO_DEPTH_HI),
    .DEPTH_LO (sao_band_pkg::SAO_DEPTH_LO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid   (cfg_valid),
    .cfg_ready   (cfg_ready),
    .cfg_depth12 (cfg_depth12),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_pixel   (out_pixel),
    .out_eol     (out_eol),
    .out_eob     (out_eob)
);

// File: tb/sao_band_stage_bench.sv
`timescale 1ns/1ps
module sao_band_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_valid;
    logic        cfg_ready;
    logic        cfg_depth12;
    logic [4:0]  cfg_start_band;
    logic [63:0] cfg_band_offs;
    logic [2:0]  cfg_width_sel;
    logic [15:0] cfg_rows_m1;
    logic        in_valid;
    logic        in_ready;
    logic [11:0] in_pixel;
    logic        out_valid;
    logic        out_ready;
    logic [11:0] out_pixel;
    logic        out_eol;
    logic        out_eob;

    always #2 clk = ~clk;

    sao_band_stage u_sao_band_stage (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_valid      (cfg_valid),
        .cfg_ready      (cfg_ready),
        .cfg_depth12    (cfg_depth12),
        .cfg_start_band (cfg_start_band),
        .cfg_band_offs  (cfg_band_offs),
        .cfg_width_sel  (cfg_width_sel),
        .cfg_rows_m1    (cfg_rows_m1),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_pixel       (in_pixel),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_pixel      (out_pixel),
        .out_eol        (out_eol),
        .out_eob        (out_eob)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] lfsr = 16'hACE1;

    int q_val[$];
    int q_kind[$];
    int q_stamp[$];
    bit q_eol[$];
    bit q_eob[$];
    bit q_r5[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model of R1..R4: kind 0 = passed through, 1 = corrected, 2 = clipped.
    function automatic int model(input int raw, input bit d12, input int start,
                                 input int offs[4], output int kind);
        int d, s, band, rel, off, sum, maxv;
        d    = d12 ? 12 : 10;
        maxv = (1 << d) - 1;
        s    = raw & maxv;
        band = s >> (d - 5);
        rel  = (band - start) & 31;
        off  = (rel < 4) ? offs[rel] : 0;
        kind = (rel < 4) ? 1 : 0;
        sum  = s + off;
        if (sum < 0)    begin sum = 0;    kind = 2; end
        if (sum > maxv) begin sum = maxv; kind = 2; end
        return sum;
    endfunction

    function automatic int gen_px(input int px, input bit d12, input int seed);
        int d, band, low, s;
        d    = d12 ? 12 : 10;
        band = (px * 7 + seed) % 32;
        low  = (px * 37 + seed * 11) & ((1 << (d - 5)) - 1);
        s    = (band << (d - 5)) | low;
        if (px % 16 == 5)  s = 0;
        if (px % 16 == 11) s = (1 << d) - 1;
        if (!d12) s = s | ((px & 3) << 10);
        return s;
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic run_block(input bit d12, input int start, input int offs[4],
                             input int wsel, input int rows_m1, input int mode,
                             input bit garbage, input int seed);
        int w, total, px, cyc, exp_col, kind, ev;
        bit hold_pend;
        logic [11:0] held;
        w = (wsel == 0) ? 8 : (wsel == 1) ? 16 : (wsel == 2) ? 32 : (wsel == 3) ? 48 : 64;
        total = w * (rows_m1 + 1);
        @(posedge clk); #1;
        while (!cfg_ready) begin @(posedge clk); #1; end
        cfg_valid      = 1'b1;
        cfg_depth12    = d12;
        cfg_start_band = 5'(start);
        for (int k = 0; k < 4; k++) cfg_band_offs[k*16 +: 16] = 16'(offs[k]);
        cfg_width_sel  = 3'(wsel);
        cfg_rows_m1    = 16'(rows_m1);
        @(posedge clk); #1;
        cfg_valid = garbage;
        px = 0; cyc = 0; exp_col = 0; hold_pend = 0; held = '0;
        while (px < total || q_val.size() > 0) begin
            step_lfsr();
            in_valid  = (px < total) && (mode == 0 || lfsr[0] || lfsr[3]);
            in_pixel  = 12'(gen_px(px, d12, seed));
            out_ready = (mode == 0) ? 1'b1 : (lfsr[5] | lfsr[9]);
            if (garbage) begin
                // R10: configuration lines churn during the block
                cfg_depth12    = lfsr[2];
                cfg_start_band = lfsr[8:4];
                cfg_band_offs  = {lfsr, ~lfsr, lfsr ^ 16'h5A5A, lfsr + 16'd77};
                cfg_width_sel  = lfsr[11:9];
                cfg_rows_m1    = lfsr;
            end
            @(negedge clk);
            if (hold_pend) begin
                chk(out_valid && out_pixel == held, "R7 stalled output changed", int'(out_pixel), int'(held));
            end
            hold_pend = out_valid && !out_ready;
            held      = out_pixel;
            if (px == total) begin
                chk(!in_ready, "R8 in_ready after block end", int'(in_ready), 0);
            end
            if (out_valid && out_ready) begin
                if (q_val.size() == 0) begin
                    chk(1'b0, "R6 unexpected output", int'(out_pixel), -1);
                end else begin
                    ev   = q_val.pop_front();
                    kind = q_kind.pop_front();
                    chk(int'(out_pixel) == ev,
                        $sformatf("%s%s pixel", (kind == 2) ? "R4" : (kind == 1) ? "R1,R2" : "R3",
                                  q_r5[0] ? ",R5" : ""),
                        int'(out_pixel), ev);
                    void'(q_r5.pop_front());
                    chk(out_eol == q_eol[0], "R9 eol", int'(out_eol), int'(q_eol[0]));
                    chk(out_eob == q_eob[0], "R9 eob", int'(out_eob), int'(q_eob[0]));
                    void'(q_eol.pop_front());
                    void'(q_eob.pop_front());
                    if (mode == 0) begin
                        chk(cyc == q_stamp[0] + 2, "R6 latency", cyc - q_stamp[0], 2);
                    end
                    void'(q_stamp.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                q_val.push_back(model(int'(in_pixel), d12, start, offs, kind));
                q_kind.push_back(kind);
                q_r5.push_back(!d12 && in_pixel[11:10] != 2'b00);
                q_stamp.push_back(cyc);
                q_eol.push_back(exp_col == w - 1);
                q_eob.push_back(px == total - 1);
                exp_col = (exp_col == w - 1) ? 0 : exp_col + 1;
                px++;
            end
            @(posedge clk); #1;
            cyc++;
        end
        in_valid  = 1'b0;
        cfg_valid = 1'b0;
        out_ready = 1'b1;
        // R8: exact pixel count, then idle again
        chk(cfg_ready && !in_ready && !out_valid, "R8 idle after block",
            int'({cfg_ready, in_ready, out_valid}), 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int offs[4];
        rst_n = 1'b0;
        cfg_valid = 1'b0; cfg_depth12 = 1'b0; cfg_start_band = '0; cfg_band_offs = '0;
        cfg_width_sel = '0; cfg_rows_m1 = '0; in_valid = 1'b0; in_pixel = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!out_valid, "R11 out_valid after reset", int'(out_valid), 0);
        chk(!in_ready,  "R11 in_ready after reset",  int'(in_ready), 0);
        chk(cfg_ready,  "R11 cfg_ready after reset", int'(cfg_ready), 1);

        // R1, R2, R3, R4: every start band at both depths, wrap past band 31
        for (int d = 0; d < 2; d++) begin
            for (int st = 0; st < 32; st++) begin
                for (int k = 0; k < 4; k++) offs[k] = ((st * 53 + k * 911 + d * 77) % 4001) - 2000;
                run_block(d[0], st, offs, 4, 0, st % 2, 1'b0, st);
            end
        end

        // R4: extreme corrections must clip, not wrap
        offs[0] = -32768; offs[1] = 32767; offs[2] = -1; offs[3] = 1;
        run_block(1'b0, 31, offs, 4, 1, 0, 1'b0, 3);
        run_block(1'b1, 30, offs, 4, 1, 1, 1'b0, 9);

        // R8, R9, R10: every width code, three rows, churned configuration
        offs[0] = 100; offs[1] = -100; offs[2] = 900; offs[3] = -900;
        for (int w = 0; w < 8; w++) begin
            run_block(1'b1, 29, offs, w, 2, 1, 1'b1, w);
        end
        run_block(1'b0, 2, offs, 0, 4, 0, 1'b1, 5);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule